// File: doc/BRIEF.md
# Oscillator Edge-Timestamp Current Estimator

This block sits behind a time-to-digital converter. The converter timestamps every transition of a free-running oscillator whose frequency moves with an input current. Each timestamp arrives tagged as a rising or a falling transition. The block keeps a short history of timestamps for each polarity. For each new edge it measures the interval back to the like edge `n` places earlier and subtracts `n` times a nominal period. It then multiplies the deviation by a programmable reciprocal gain, shifts the product arithmetically into a saturated signed 16-bit current estimate, and pulses a valid strobe.

The span `n` trades output rate against resolution. A longer span makes the measured deviation larger in proportion to `n`, while the timing jitter grows only with its square root. The nominal period can be loaded directly. It can also be learned: the block averages the first 256 single-edge periods that follow a calibrate command.

Top module: `edge_current_est`

## Requirements
- R1: After reset `est_valid`, `est_value`, `nom_value` and `cal_busy` are all zero.
- R2: An estimate for an edge uses only earlier edges of the same polarity, and `est_pol` repeats that edge's polarity (1 = rising, 0 = falling).
- R3: An edge produces an estimate only if at least `n` earlier edges of its polarity have been stored since reset.
- R4: The interval is the 24-bit modulo difference of the timestamps, so a wrap of the converter's counter gives the correct interval.
- R5: Deviation is the interval minus `n * nom_value`. The estimate is `floor(deviation * gain / 2^8)`, where `gain` is unsigned.
- R6: A result above 32767 is output as 32767, and a result below -32768 is output as -32768.
- R7: The effective span is `span` for values 1 to 16. A `span` of 0 acts as 1, and any value above 16 acts as 16.
- R8: `est_valid` is a one-cycle pulse, raised in the cycle after the timestamp that produced it was accepted.
- R9: A `nom_wr` loads `nom_wdata` into `nom_value` on the next edge of the clock and ends any calibration in progress. Without a write or a calibration, `nom_value` holds its value.
- R10: After `cal_start`, `cal_busy` stays high until 256 span-1 periods of either polarity have been seen. `nom_value` then becomes the floor of their mean, and no estimate is output while `cal_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_valid | input | 1 | A timestamp is present this cycle |
| ts_pol | input | 1 | Polarity of the transition, 1 = rising |
| ts_time | input | 24 | Timestamp in converter LSBs |
| span | input | 5 | Edge span n |
| gain | input | 16 | Unsigned reciprocal gain, applied before the shift by 8 |
| nom_wr | input | 1 | Load the nominal period directly |
| nom_wdata | input | 24 | Nominal period value to load |
| cal_start | input | 1 | Begin learning the nominal period |
| est_valid | output | 1 | Estimate strobe |
| est_pol | output | 1 | Polarity the estimate belongs to |
| est_value | output | 16 | Signed, saturated current estimate |
| nom_value | output | 24 | Current nominal period |
| cal_busy | output | 1 | Calibration in progress |

## Verification
The embedded properties check on every cycle the following:
- the strobe appears only one cycle after an accepted timestamp;
- the polarity echoes that timestamp;
- no estimate leaks out during calibration;
- the nominal period changes only through a write or a calibration.

The arithmetic of the estimate can only be shown by the bench scenarios, which compare against a behavioural model on every clock. These cover the per-polarity histories, the history fill rule, counter wrap, the clamping of the span, saturation at both rails, and the averaging of calibration.

// File: rtl/edge_current_est.sv
module edge_current_est #(
  parameter int TS_W     = 24,
  parameter int OUT_W    = 16,
  parameter int GAIN_W   = 16,
  parameter int SHIFT    = 8,
  parameter int MAX_SPAN = 16,   // power of two
  parameter int CAL_LOG2 = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ts_valid,
  input  logic                           ts_pol,
  input  logic [TS_W-1:0]                ts_time,
  input  logic [$clog2(MAX_SPAN+1)-1:0]  span,
  input  logic [GAIN_W-1:0]              gain,
  input  logic                           nom_wr,
  input  logic [TS_W-1:0]                nom_wdata,
  input  logic                           cal_start,
  output logic                           est_valid,
  output logic                           est_pol,
  output logic signed [OUT_W-1:0]        est_value,
  output logic [TS_W-1:0]                nom_value,
  output logic                           cal_busy
);
  localparam int PTR_W  = $clog2(MAX_SPAN);
  localparam int SPAN_W = $clog2(MAX_SPAN + 1);
  localparam int NS_W   = TS_W + SPAN_W;
  localparam int DEV_W  = NS_W + 1;
  localparam int PROD_W = DEV_W + GAIN_W + 1;
  localparam int ACC_W  = TS_W + CAL_LOG2;

  logic [TS_W-1:0]   hist [2][MAX_SPAN];
  logic [PTR_W-1:0]  wptr [2];
  logic [SPAN_W-1:0] fill [2];
  logic [ACC_W-1:0]  acc;
  logic [CAL_LOG2-1:0] cal_cnt;

  logic [SPAN_W-1:0] span_eff;
  logic [TS_W-1:0]   old_n, old_1, ival_n, ival_1;
  logic [NS_W-1:0]   nom_span;
  logic signed [DEV_W-1:0]  dev;
  logic signed [GAIN_W:0]   gain_s;
  logic signed [PROD_W-1:0] prod, scaled;
  logic [PROD_W-OUT_W:0]    top;
  logic signed [OUT_W-1:0]  clipped;
  logic fire, take, done;
  logic [ACC_W-1:0] acc_nx;

  assign span_eff = (span == '0) ? SPAN_W'(1) :
                    (span > SPAN_W'(MAX_SPAN)) ? SPAN_W'(MAX_SPAN) : span;

  assign old_n  = hist[ts_pol][wptr[ts_pol] - span_eff[PTR_W-1:0]];
  assign old_1  = hist[ts_pol][wptr[ts_pol] - PTR_W'(1)];
  assign ival_n = ts_time - old_n;
  assign ival_1 = ts_time - old_1;

  assign nom_span = NS_W'(nom_value) * NS_W'(span_eff);
  assign dev      = $signed({1'b0, NS_W'(ival_n)}) - $signed({1'b0, nom_span});
  assign gain_s   = $signed({1'b0, gain});
  assign prod     = PROD_W'(dev) * PROD_W'(gain_s);
  assign scaled   = prod >>> SHIFT;
  assign top      = scaled[PROD_W-1:OUT_W-1];
  assign clipped  = (&top || ~|top) ? scaled[OUT_W-1:0] :
                    scaled[PROD_W-1] ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}};

  assign fire   = ts_valid && !cal_busy && (fill[ts_pol] >= span_eff);
  assign take   = ts_valid && cal_busy && (fill[ts_pol] != '0);
  assign acc_nx = acc + ACC_W'(ival_1);
  assign done   = take && (&cal_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        wptr[p] <= '0;
        fill[p] <= '0;
      end
      est_valid <= 1'b0;
      est_pol   <= 1'b0;
      est_value <= '0;
      nom_value <= '0;
      cal_busy  <= 1'b0;
      acc       <= '0;
      cal_cnt   <= '0;
    end else begin
      if (ts_valid) begin
        hist[ts_pol][wptr[ts_pol]] <= ts_time;
        wptr[ts_pol] <= wptr[ts_pol] + PTR_W'(1);
        if (fill[ts_pol] != SPAN_W'(MAX_SPAN)) fill[ts_pol] <= fill[ts_pol] + SPAN_W'(1);
      end
      est_valid <= fire;
      if (fire) begin
        est_value <= clipped;
        est_pol   <= ts_pol;
      end
      if (nom_wr) begin
        nom_value <= nom_wdata;
        cal_busy  <= 1'b0;
      end else if (cal_start) begin
        cal_busy <= 1'b1;
        acc      <= '0;
        cal_cnt  <= '0;
      end else if (take) begin
        acc <= acc_nx;
        cal_cnt <= cal_cnt + CAL_LOG2'(1);
        if (done) begin
          nom_value <= acc_nx[ACC_W-1:CAL_LOG2];
          cal_busy  <= 1'b0;
        end
      end
    end
  end

  p_valid_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid |-> $past(ts_valid));
  p_pol_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid |-> est_pol == $past(ts_pol));
  p_quiet_cal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid |-> !$past(cal_busy));
  p_nom_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(nom_wr) && !$past(cal_busy)) |-> $stable(nom_value));
  p_wr_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(nom_wr) |-> (nom_value == $past(nom_wdata)) && !cal_busy);
endmodule

// File: tb/edge_current_est_bench.sv
module edge_current_est_bench;
  localparam int CLK_PERIOD = 10;
  localparam longint MASK = 64'hFFFFFF;

  logic clk = 0, rst_n = 0;
  logic ts_valid = 0, ts_pol = 0;
  logic [23:0] ts_time = 0;
  logic [4:0] span = 1;
  logic [15:0] gain = 0;
  logic nom_wr = 0, cal_start = 0;
  logic [23:0] nom_wdata = 0;
  logic est_valid, est_pol, cal_busy;
  logic signed [15:0] est_value;
  logic [23:0] nom_value;

  edge_current_est u_edge_current_est (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, n_est = 0, cyc = 0;
  bit seen_hi = 0, seen_lo = 0;
  string scen = "R1 reset";
  longint tnow = 1000;

  // behavioural reference
  longint hq[2][$];
  longint m_nom = 0, m_acc = 0, m_val = 0;
  int m_cnt = 0;
  bit m_busy = 0, m_valid = 0, m_pol = 0;

  task automatic chk(string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", scen, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    longint old, iv, dev, sh;
    int s;
    bit p;
    if (!rst_n) begin
      hq[0].delete(); hq[1].delete();
      m_nom = 0; m_acc = 0; m_val = 0; m_cnt = 0; m_busy = 0; m_valid = 0; m_pol = 0;
    end else begin
      s = (span == 0) ? 1 : (span > 16) ? 16 : int'(span);
      p = ts_pol;
      m_valid = 0;
      if (ts_valid && !m_busy && hq[p].size() >= s) begin
        old = hq[p][hq[p].size() - s];
        iv  = (longint'(ts_time) - old) & MASK;
        dev = iv - m_nom * s;
        sh  = (dev * longint'(gain)) >>> 8;
        if (sh > 32767) sh = 32767;
        if (sh < -32768) sh = -32768;
        m_val = sh; m_pol = p; m_valid = 1;
      end
      if (nom_wr) begin
        m_nom = nom_wdata; m_busy = 0;
      end else if (cal_start) begin
        m_busy = 1; m_acc = 0; m_cnt = 0;
      end else if (m_busy && ts_valid && hq[p].size() >= 1) begin
        m_acc += (longint'(ts_time) - hq[p][$]) & MASK;
        if (m_cnt == 255) begin m_nom = m_acc >> 8; m_busy = 0; end
        else m_cnt++;
      end
      if (ts_valid) begin
        hq[p].push_back(longint'(ts_time));
        if (hq[p].size() > 16) void'(hq[p].pop_front());
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R8 strobe", est_valid, m_valid);
      if (m_valid) begin
        chk("R5 value", longint'(est_value), m_val);
        chk("R2 polarity", est_pol, m_pol);
        if (m_val == 32767) seen_hi = 1;
        if (m_val == -32768) seen_lo = 1;
      end
      chk("R10 busy", cal_busy, m_busy);
      chk("R10 nominal", nom_value, m_nom);
      if (est_valid) n_est++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic edge_in(bit pol, longint t);
    @(negedge clk);
    ts_valid = 1; ts_pol = pol; ts_time = t[23:0];
    @(negedge clk);
    ts_valid = 0;
  endtask

  task automatic run(int n, int base, int jit);
    for (int i = 0; i < n; i++) begin
      int per;
      per = base + ((i * 5) % (2 * jit + 1)) - jit;
      edge_in(1, tnow & MASK);
      edge_in(0, (tnow + per / 2) & MASK);
      tnow += per;
    end
  endtask

  task automatic write_nom(int v);
    @(negedge clk); nom_wr = 1; nom_wdata = v[23:0];
    @(negedge clk); nom_wr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 est_valid", est_valid, 0);
    chk("R1 est_value", longint'(est_value), 0);
    chk("R1 nom_value", nom_value, 0);
    chk("R1 cal_busy", cal_busy, 0);

    write_nom(100);
    gain = 16'd256;
    span = 5'd3;
    scen = "R3 fill";
    n_est = 0;
    for (int i = 0; i < 3; i++) begin edge_in(1, tnow); tnow += 97; end
    @(negedge clk);
    chk("R3 no estimate yet", n_est, 0);
    edge_in(1, tnow); tnow += 97;
    @(negedge clk);
    chk("R3 first estimate", n_est, 1);

    scen = "R5 span1"; span = 1; run(20, 100, 3);
    scen = "R2 mixed"; span = 2; gain = 16'd1000; run(20, 104, 6);
    scen = "R7 span4"; span = 4; run(20, 98, 5);
    scen = "R7 span16"; span = 16; run(40, 101, 7);
    scen = "R7 span0"; span = 0; run(12, 99, 2);
    scen = "R7 span20"; span = 20; run(40, 100, 4);

    scen = "R4 wrap"; span = 3; gain = 16'd300;
    tnow = 64'h1000000 - 700;
    run(20, 100, 5);

    scen = "R6 saturation"; span = 1; gain = 16'hFFFF;
    run(6, 300, 0);
    write_nom(1000);
    run(6, 10, 0);
    chk("R6 high rail seen", seen_hi, 1);
    chk("R6 low rail seen", seen_lo, 1);

    scen = "R10 calibrate"; gain = 16'd256;
    @(negedge clk); cal_start = 1; @(negedge clk); cal_start = 0;
    run(150, 103, 9);
    chk("R10 finished", cal_busy, 0);
    run(10, 103, 9);

    scen = "R9 write aborts";
    @(negedge clk); cal_start = 1; @(negedge clk); cal_start = 0;
    run(10, 90, 3);
    chk("R9 still busy", cal_busy, 1);
    write_nom(555);
    chk("R9 loaded", nom_value, 555);
    chk("R9 busy cleared", cal_busy, 0);
    run(10, 555, 4);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule